// File: doc/BRIEF.md
# Dual-Port Two-Word Burst DDR SRAM

This block is a synthesizable model of a synchronous static memory with one port for reads and a separate port for writes. Both ports may start an access on the same rising edge of the input clock, and every access moves a burst of two words, one per half-cycle. The first word of a burst lives in an even bank and the second in an odd bank, both addressed by the same burst address.

A write is requested by pulling the write select low at a rising input-clock edge. The first data word and its per-lane write enables are taken on that edge and the second word and its enables on the following falling edge. A read is requested by pulling the read select low at a rising input-clock edge. The two words leave the block on the two edges of the output clock, with an output-enable flag in place of a tri-state driver. A mode input lets the input clock also time the outputs. A pair of echo clocks follows whichever clock times the outputs. A read that starts on the same edge as a write to the same address sees that write, merged lane by lane with the older contents.

Top module: `sep_port_burst_sram`

## Requirements
- R1: While reset is high and after its release, `rd_oe` is low and `rd_data` is zero until a read has been accepted.
- R2: A read accepted at rising input edge n drives the even word on the output-clock falling edge 1.5 cycles later and the odd word on the next output-clock rising edge, with `rd_oe` high for both half-cycles.
- R3: A write accepted at a rising input edge stores `wr_data` of that edge in the even word and `wr_data` of the following falling edge in the odd word of `wr_addr`.
- R4: Lane i occupies bits [i*LW +: LW] (LW is 9 for widths 18 and 36, 8 for width 8); an active-low `wr_be_n[i]` taken with each word gates that lane, and a high bit leaves the lane's old contents.
- R5: A read accepted on the same rising edge as a write to the same address returns the new data of both words, lane-merged under that write's enables.
- R6: A write accepted one cycle after a read to the same address does not change that read's result.
- R7: A rising edge with `rd_sel_n` high starts no read; after the odd word of the last burst, `rd_oe` drops at the next output-clock falling edge and `rd_data` returns to zero.
- R8: Reads on consecutive rising edges produce an unbroken run of words with `rd_oe` held high.
- R9: With `single_clk_mode` high the outputs are timed by `clk` and `out_clk` has no effect.
- R10: `echo_clk` equals the clock timing the outputs (`out_clk`, or `clk` in single-clock mode) and `echo_clk_n` is its complement.
- R11: A read and a write to different addresses on the same edge both complete, the read returning the earlier contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; rising edge takes selects, addresses and first write word, falling edge takes the second |
| rst | input | 1 | Synchronous active-high reset of pipeline state |
| single_clk_mode | input | 1 | High: outputs timed by `clk` instead of `out_clk` |
| out_clk | input | 1 | Output clock; falling edge drives the even word, rising edge the odd word |
| rd_sel_n | input | 1 | Active-low read request |
| rd_addr | input | AW | Read burst address |
| wr_sel_n | input | 1 | Active-low write request |
| wr_addr | input | AW | Write burst address |
| wr_data | input | W | Write word, taken on both input-clock edges |
| wr_be_n | input | W/LW | Active-low lane write enables, taken on both input-clock edges |
| rd_data | output | W | Read word, zero when not enabled |
| rd_oe | output | 1 | High while `rd_data` carries a burst word |
| echo_clk | output | 1 | Copy of the output timing clock |
| echo_clk_n | output | 1 | Complement of `echo_clk` |

## Verification
The bench mixes isolated reads separated by idle cycles, which separate the start and end of the enable window, with runs of consecutive reads that expose any gap or overlap between bursts. Writes with full, partial and complementary lane masks on the two halves tell a swapped half or a wrong lane apart from a correct merge. Same-address read and write on one edge, read followed one cycle later by a write to that address, and a different-address pair pin down exactly which writes a read may observe. The same traffic is then repeated in single-clock mode with the output clock stopped.

// File: rtl/b2sram_pkg.sv
package b2sram_pkg;

    // Lane width: 9-bit lanes carry a parity-style extra bit, 8-bit words are one lane.
    function automatic int unsigned lane_bits(input int unsigned width);
        return (width == 8) ? 8 : 9;
    endfunction

    function automatic int unsigned lane_count(input int unsigned width);
        return width / lane_bits(width);
    endfunction

    // Which clock edge a storage element or output register acts on.
    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } edge_e;

endpackage

// File: rtl/b2_bank.sv
module b2_bank
    import b2sram_pkg::*;
#(
    parameter int    W       = 18,
    parameter int    AW      = 8,
    parameter int    LW      = 9,
    parameter int    NL      = 2,
    parameter edge_e WR_EDGE = EDGE_RISE
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [NL-1:0] wbe_n,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] mem [DEPTH];

    generate
        if (WR_EDGE == EDGE_FALL) begin : g_fall
            always_ff @(negedge clk) begin
                for (int i = 0; i < NL; i++) begin
                    if (we && !wbe_n[i]) begin
                        mem[waddr][i*LW +: LW] <= wdata[i*LW +: LW];
                    end
                end
            end
        end else begin : g_rise
            always_ff @(posedge clk) begin
                for (int i = 0; i < NL; i++) begin
                    if (we && !wbe_n[i]) begin
                        mem[waddr][i*LW +: LW] <= wdata[i*LW +: LW];
                    end
                end
            end
        end
    endgenerate

    assign rdata = mem[raddr];

endmodule

// File: rtl/b2_wr_path.sv
module b2_wr_path
    import b2sram_pkg::*;
#(
    parameter int W  = 18,
    parameter int AW = 8,
    parameter int NL = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_sel_n,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic [NL-1:0] wr_be_n,
    output logic          even_we,
    output logic [AW-1:0] even_addr,
    output logic [W-1:0]  even_data,
    output logic [NL-1:0] even_be_n,
    output logic          odd_we,
    output logic [AW-1:0] odd_addr,
    output logic [W-1:0]  odd_data,
    output logic [NL-1:0] odd_be_n
);
    typedef struct packed {
        logic          v;
        logic [AW-1:0] a;
        logic [W-1:0]  d;
        logic [NL-1:0] be_n;
    } beat_t;

    beat_t first_q;   // taken on the rising edge
    beat_t second_q;  // taken on the following falling edge

    always_ff @(posedge clk) begin
        if (rst) begin
            first_q.v <= 1'b0;
        end else begin
            first_q.v <= !wr_sel_n;
        end
        first_q.a    <= wr_addr;
        first_q.d    <= wr_data;
        first_q.be_n <= wr_be_n;
    end

    always_ff @(negedge clk) begin
        if (rst) begin
            second_q.v <= 1'b0;
        end else begin
            second_q.v <= first_q.v;
        end
        second_q.a    <= first_q.a;
        second_q.d    <= wr_data;
        second_q.be_n <= wr_be_n;
    end

    // Even bank commits on the falling edge, odd bank on the next rising edge.
    assign even_we   = first_q.v;
    assign even_addr = first_q.a;
    assign even_data = first_q.d;
    assign even_be_n = first_q.be_n;

    assign odd_we    = second_q.v;
    assign odd_addr  = second_q.a;
    assign odd_data  = second_q.d;
    assign odd_be_n  = second_q.be_n;

endmodule

// File: rtl/b2_rd_path.sv
module b2_rd_path
    import b2sram_pkg::*;
#(
    parameter int W  = 18,
    parameter int AW = 8,
    parameter int LW = 9,
    parameter int NL = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_sel_n,
    input  logic [AW-1:0] rd_addr,
    output logic [AW-1:0] bank_raddr,
    input  logic [W-1:0]  even_rdata,
    input  logic [W-1:0]  odd_rdata,
    input  logic          odd_we,
    input  logic [AW-1:0] odd_addr,
    input  logic [W-1:0]  odd_data,
    input  logic [NL-1:0] odd_be_n,
    output logic          hold_v,
    output logic [W-1:0]  hold_lo,
    output logic [W-1:0]  hold_hi
);
    logic          acc_v;
    logic [AW-1:0] acc_a;
    logic          fwd_hit;
    logic [W-1:0]  odd_merged;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_v <= 1'b0;
        end else begin
            acc_v <= !rd_sel_n;
        end
        acc_a <= rd_addr;
    end

    assign bank_raddr = acc_a;

    // The odd word of a same-cycle write is still in flight when the
    // bank is read; take its enabled lanes straight from the write stage.
    assign fwd_hit = odd_we && (odd_addr == acc_a);

    generate
        for (genvar g = 0; g < NL; g++) begin : g_lane
            assign odd_merged[g*LW +: LW] = (fwd_hit && !odd_be_n[g])
                                            ? odd_data[g*LW +: LW]
                                            : odd_rdata[g*LW +: LW];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_v <= 1'b0;
        end else begin
            hold_v <= acc_v;
        end
        hold_lo <= even_rdata;
        hold_hi <= odd_merged;
    end

endmodule

// File: rtl/b2_ddr_out.sv
module b2_ddr_out
    import b2sram_pkg::*;
#(
    parameter int W = 18
) (
    input  logic         oclk,
    input  logic         rst,
    input  logic         hold_v,
    input  logic [W-1:0] hold_lo,
    input  logic [W-1:0] hold_hi,
    output logic [W-1:0] q,
    output logic         oe
);
    logic         fall_v, rise_v, sec_v;
    logic [W-1:0] fall_d, rise_d, sec_d;
    logic         tog_f, tog_r;
    edge_e        latest;

    always_ff @(negedge oclk) begin
        if (rst) begin
            fall_v <= 1'b0;
            sec_v  <= 1'b0;
            tog_f  <= 1'b0;
        end else begin
            fall_v <= hold_v;
            sec_v  <= hold_v;
            tog_f  <= !tog_r;
        end
        fall_d <= hold_lo;
        sec_d  <= hold_hi;
    end

    always_ff @(posedge oclk) begin
        if (rst) begin
            rise_v <= 1'b0;
            tog_r  <= 1'b0;
        end else begin
            rise_v <= sec_v;
            tog_r  <= tog_f;
        end
        rise_d <= sec_d;
    end

    // Toggles differ right after a falling edge, agree after a rising edge.
    assign latest = (tog_f ^ tog_r) ? EDGE_FALL : EDGE_RISE;

    always_comb begin
        if (latest == EDGE_FALL) begin
            oe = fall_v;
            q  = fall_v ? fall_d : '0;
        end else begin
            oe = rise_v;
            q  = rise_v ? rise_d : '0;
        end
    end

endmodule

// File: rtl/sep_port_burst_sram.sv
module sep_port_burst_sram
    import b2sram_pkg::*;
#(
    parameter  int W  = 18,
    parameter  int AW = 8,
    localparam int LW = lane_bits(W),
    localparam int NL = lane_count(W)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          single_clk_mode,
    input  logic          out_clk,
    input  logic          rd_sel_n,
    input  logic [AW-1:0] rd_addr,
    input  logic          wr_sel_n,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic [NL-1:0] wr_be_n,
    output logic [W-1:0]  rd_data,
    output logic          rd_oe,
    output logic          echo_clk,
    output logic          echo_clk_n
);
    logic          oclk;
    logic          even_we, odd_we;
    logic [AW-1:0] even_addr, odd_addr, bank_raddr;
    logic [W-1:0]  even_data, odd_data, even_rdata, odd_rdata;
    logic [NL-1:0] even_be_n, odd_be_n;
    logic          hold_v;
    logic [W-1:0]  hold_lo, hold_hi;
    logic          w_stage_v, w_pend_v;

    assign oclk       = single_clk_mode ? clk : out_clk;
    assign echo_clk   = oclk;
    assign echo_clk_n = !oclk;

    b2_wr_path #(.W(W), .AW(AW), .NL(NL)) u_wr (
        .clk      (clk),
        .rst      (rst),
        .wr_sel_n (wr_sel_n),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .wr_be_n  (wr_be_n),
        .even_we  (even_we),
        .even_addr(even_addr),
        .even_data(even_data),
        .even_be_n(even_be_n),
        .odd_we   (odd_we),
        .odd_addr (odd_addr),
        .odd_data (odd_data),
        .odd_be_n (odd_be_n)
    );

    assign w_stage_v = even_we;
    assign w_pend_v  = odd_we;

    b2_bank #(.W(W), .AW(AW), .LW(LW), .NL(NL), .WR_EDGE(EDGE_FALL)) u_even (
        .clk  (clk),
        .we   (even_we),
        .waddr(even_addr),
        .wdata(even_data),
        .wbe_n(even_be_n),
        .raddr(bank_raddr),
        .rdata(even_rdata)
    );

    b2_bank #(.W(W), .AW(AW), .LW(LW), .NL(NL), .WR_EDGE(EDGE_RISE)) u_odd (
        .clk  (clk),
        .we   (odd_we),
        .waddr(odd_addr),
        .wdata(odd_data),
        .wbe_n(odd_be_n),
        .raddr(bank_raddr),
        .rdata(odd_rdata)
    );

    b2_rd_path #(.W(W), .AW(AW), .LW(LW), .NL(NL)) u_rd (
        .clk       (clk),
        .rst       (rst),
        .rd_sel_n  (rd_sel_n),
        .rd_addr   (rd_addr),
        .bank_raddr(bank_raddr),
        .even_rdata(even_rdata),
        .odd_rdata (odd_rdata),
        .odd_we    (odd_we),
        .odd_addr  (odd_addr),
        .odd_data  (odd_data),
        .odd_be_n  (odd_be_n),
        .hold_v    (hold_v),
        .hold_lo   (hold_lo),
        .hold_hi   (hold_hi)
    );

    b2_ddr_out #(.W(W)) u_out (
        .oclk   (oclk),
        .rst    (rst),
        .hold_v (hold_v),
        .hold_lo(hold_lo),
        .hold_hi(hold_hi),
        .q      (rd_data),
        .oe     (rd_oe)
    );

endmodule

// File: rtl/sep_port_burst_sram_chk.sv
module sep_port_burst_sram_chk (
    input logic clk,
    input logic rst,
    input logic rd_sel_n,
    input logic wr_sel_n,
    input logic hold_v,
    input logic w_stage_v,
    input logic w_pend_v
);
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!hold_v && !w_stage_v)); // R1

    AST_READ_REACHES_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rd_sel_n |=> ##1 hold_v); // R2

    AST_IDLE_NO_HOLD: assert property (@(posedge clk) disable iff (rst)
        rd_sel_n |=> ##1 !hold_v); // R7

    AST_WRITE_STAGED: assert property (@(posedge clk) disable iff (rst)
        !wr_sel_n |=> w_pend_v); // R3

    AST_WRITE_IDLE: assert property (@(posedge clk) disable iff (rst)
        wr_sel_n |=> !w_pend_v); // R3

endmodule

bind sep_port_burst_sram sep_port_burst_sram_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .rd_sel_n (rd_sel_n),
    .wr_sel_n (wr_sel_n),
    .hold_v   (hold_v),
    .w_stage_v(w_stage_v),
    .w_pend_v (w_pend_v)
);

// File: tb/sep_port_burst_sram_bench.sv
module sep_port_burst_sram_bench;
    localparam int W    = 18;
    localparam int AW   = 8;
    localparam int LW   = 9;
    localparam int NL   = 2;
    localparam int RING = 64;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          single_clk_mode = 1'b0;
    logic          out_en = 1'b1;
    logic          out_clk;
    logic          rd_sel_n = 1'b1;
    logic [AW-1:0] rd_addr = '0;
    logic          wr_sel_n = 1'b1;
    logic [AW-1:0] wr_addr = '0;
    logic [W-1:0]  wr_data = '0;
    logic [NL-1:0] wr_be_n = '1;
    logic [W-1:0]  rd_data;
    logic          rd_oe, echo_clk, echo_clk_n;

    always #2 clk = ~clk;
    assign out_clk = out_en ? clk : 1'b0;

    sep_port_burst_sram #(.W(W), .AW(AW)) u_sep_port_burst_sram (
        .clk(clk), .rst(rst), .single_clk_mode(single_clk_mode), .out_clk(out_clk),
        .rd_sel_n(rd_sel_n), .rd_addr(rd_addr), .wr_sel_n(wr_sel_n), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_be_n(wr_be_n), .rd_data(rd_data), .rd_oe(rd_oe),
        .echo_clk(echo_clk), .echo_clk_n(echo_clk_n)
    );

    int checks = 0;
    int fails  = 0;
    int hc     = 0;
    logic  chk_en = 1'b0;
    string cur_req = "R1";

    logic [W-1:0] m_even [1 << AW];
    logic [W-1:0] m_odd  [1 << AW];
    logic         exp_v  [RING];
    logic [W-1:0] exp_d  [RING];

    initial for (int i = 0; i < RING; i++) exp_v[i] = 1'b0;

    always @(posedge clk) hc = hc + 1;
    always @(negedge clk) hc = hc + 1;

    function automatic logic [W-1:0] mk(input int a, input int half, input int salt);
        return W'(a * 37 + half * 1013 + salt * 4099 + 5);
    endfunction

    task automatic check_slot();
        int idx;
        logic ref_clk;
        if (!chk_en) return;
        idx = hc % RING;
        checks++;
        if (exp_v[idx]) begin
            if (rd_oe !== 1'b1 || rd_data !== exp_d[idx]) begin
                fails++;
                $display("FAIL %s: oe=%b data=%h expected oe=1 data=%h", cur_req, rd_oe, rd_data, exp_d[idx]);
            end
            exp_v[idx] = 1'b0;
        end else if (rd_oe !== 1'b0 || rd_data !== '0) begin
            fails++;
            $display("FAIL %s: oe=%b data=%h expected oe=0 data=0", cur_req, rd_oe, rd_data);
        end
        // R10: echo pair follows the output timing clock
        ref_clk = single_clk_mode ? clk : out_clk;
        checks++;
        if (echo_clk !== ref_clk || echo_clk_n !== !ref_clk) begin
            fails++;
            $display("FAIL R10: echo=%b echo_n=%b expected %b %b", echo_clk, echo_clk_n, ref_clk, !ref_clk);
        end
    endtask

    always @(posedge clk) begin #1; check_slot(); end
    always @(negedge clk) begin #1; check_slot(); end

    task automatic step(input logic rd, input int ra, input logic wr, input int wa,
                        input logic [W-1:0] d0, input logic [W-1:0] d1,
                        input logic [NL-1:0] b0, input logic [NL-1:0] b1);
        int p;
        @(negedge clk); #1;
        rd_sel_n = !rd;
        rd_addr  = AW'(ra);
        wr_sel_n = !wr;
        wr_addr  = AW'(wa);
        wr_data  = d0;
        wr_be_n  = b0;
        p = hc + 1;
        if (wr) begin
            for (int i = 0; i < NL; i++) begin
                if (!b0[i]) m_even[wa][i*LW +: LW] = d0[i*LW +: LW];
                if (!b1[i]) m_odd[wa][i*LW +: LW]  = d1[i*LW +: LW];
            end
        end
        if (rd) begin
            exp_v[(p + 3) % RING] = 1'b1;
            exp_d[(p + 3) % RING] = m_even[ra];
            exp_v[(p + 4) % RING] = 1'b1;
            exp_d[(p + 4) % RING] = m_odd[ra];
        end
        @(posedge clk); #1;
        wr_data = d1;
        wr_be_n = b1;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step(0, 0, 0, 0, '0, '0, '1, '1);
    endtask

    task automatic traffic(input int salt);
        cur_req = "R3";
        for (int a = 0; a < 16; a++) step(0, 0, 1, a, mk(a, 0, salt), mk(a, 1, salt), '0, '0);
        idle(2);
        cur_req = "R2";
        step(1, 2, 0, 0, '0, '0, '1, '1);
        idle(3);
        step(1, 9, 0, 0, '0, '0, '1, '1);
        idle(1);
        cur_req = "R8";
        for (int a = 0; a < 8; a++) step(1, a, 0, 0, '0, '0, '1, '1);
        idle(3);
        cur_req = "R4";
        step(0, 0, 1, 3, mk(50, 0, salt), mk(50, 1, salt), 2'b01, 2'b10);
        idle(1);
        step(1, 3, 0, 0, '0, '0, '1, '1);
        idle(3);
        cur_req = "R5";
        step(1, 5, 1, 5, mk(60, 0, salt), mk(60, 1, salt), 2'b00, 2'b01);
        step(1, 5, 0, 0, '0, '0, '1, '1);
        idle(3);
        cur_req = "R6";
        step(1, 6, 0, 0, '0, '0, '1, '1);
        step(0, 0, 1, 6, mk(70, 0, salt), mk(70, 1, salt), '0, '0);
        step(1, 6, 0, 0, '0, '0, '1, '1);
        idle(3);
        cur_req = "R11";
        step(1, 7, 1, 8, mk(80, 0, salt), mk(80, 1, salt), '0, '0);
        step(1, 8, 0, 0, '0, '0, '1, '1);
        idle(3);
        cur_req = "R7";
        step(1, 1, 0, 0, '0, '0, '1, '1);
        idle(6);
    endtask

    initial begin
        #(4 * 100000);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (6) @(posedge clk);
        #1;
        chk_en = 1'b1;   // R1: outputs checked idle while reset still held
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        cur_req = "R1";
        idle(4);
        traffic(1);
        // R9: switch to single-clock mode with the output clock stopped
        @(negedge clk); #1;
        single_clk_mode = 1'b1;
        out_en = 1'b0;
        cur_req = "R9";
        idle(2);
        traffic(2);
        cur_req = "R9";
        idle(4);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule